// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the memory side of a 16-bit processor bus that carries a 20-bit byte address. Storage is split into two byte-wide banks, one holding even-addressed bytes and one holding odd-addressed bytes. A high-byte enable and address bit 0 together choose which banks take part in a cycle, so one cycle can move a full 16-bit word or a single byte.

The upper address bits are decoded into two chip selects: one for a read-only program region at the top of the space and one for a read/write data region at the bottom. The `full_dec` input chooses between two decoding modes. In exact mode every bit above the bank index must match. In partial mode only the top address bit is examined, so the data region also answers at many shadow addresses.

Reads are registered, so data appears one clock after the read strobe is sampled low. Writes take effect on the clock edge while the write strobe is low. The program region's contents are preset from a fixed arithmetic pattern of the bank index.

Top module: `banked_mem_decoder`

## Requirements
- R1: While `rst` is high, and after it is released until the first sampled read, `rdata` is 16'hFFFF.
- R2: Lane enables: `bhe_n`=0,`addr[0]`=0 gives word (`even_en`=1,`odd_en`=1); `bhe_n`=1,`addr[0]`=0 gives even byte only; `bhe_n`=0,`addr[0]`=1 gives odd byte only; `bhe_n`=1,`addr[0]`=1 gives neither.
- R3: With `full_dec`=1, `ram_cs` is high only when `addr[19:9]` is all zeros and `rom_cs` is high only when `addr[19:9]` is all ones. Every other pattern raises neither select.
- R4: With `full_dec`=0, `addr[19]`=0 raises `ram_cs` and `addr[19]`=1 raises `rom_cs`. Bits 18:9 are ignored, so a data cell is reached at every value of those bits.
- R5: The reset address 20'hFFF0 extended to 20'hFFFF0 lies in the program region in both modes.
- R6: The bank index is `addr[8:1]`. Program region byte at index i reads as the low 8 bits of i*29+8'h11 in the even bank and i*29+8'h6B in the odd bank.
- R7: A write strobe in the program region changes nothing: later reads still return the R6 pattern.
- R8: A RAM write updates only the enabled lanes. The even byte comes from `wdata[7:0]` and the odd byte from `wdata[15:8]`.
- R9: `rdata` loads only at a rising edge where `rd_n` is low and holds while `rd_n` is high.
- R10: In read data, the even bank drives bits 7:0 and the odd bank drives bits 15:8. A disabled lane reads 8'hFF, and an address in no region reads 16'hFFFF.
- R11: A read and a write to the same cell at the same edge return the contents from before the write.
- R12: `rom_cs` and `ram_cs` are never high together, and they depend on the address and mode only, not on the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_dec | input | 1 | 1 selects exact decoding, 0 selects top-bit-only decoding |
| addr | input | 20 | Byte address |
| bhe_n | input | 1 | Active-low high-byte enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data, odd byte on 15:8 |
| rdata | output | 16 | Registered read data |
| rom_cs | output | 1 | Program region selected |
| ram_cs | output | 1 | Data region selected |
| even_en | output | 1 | Even bank lane enabled |
| odd_en | output | 1 | Odd bank lane enabled |

## Verification
Decode faults show up at once: a wrong select or lane enable is visible on the combinational outputs in the same cycle the address is applied. A write that lands in the wrong bank, lane or cell, or a write that reaches the program region, stays hidden until that cell is read. The bench therefore keeps a full byte model of both banks and compares every registered read one edge after its strobe. Aliasing mistakes in partial mode are caught by reading, through shadow addresses, data that was written at page-0 addresses.

// File: rtl/memdec_pkg.sv
`timescale 1ns/1ps
package memdec_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_EVEN = 2'b01,
        LANE_ODD  = 2'b10,
        LANE_WORD = 2'b11
    } lane_e;

    typedef struct packed {
        logic rom;
        logic ram;
    } region_t;

    function automatic lane_e lane_of(input logic bhe_n, input logic a0);
        case ({bhe_n, a0})
            2'b00:   return LANE_WORD;
            2'b10:   return LANE_EVEN;
            2'b01:   return LANE_ODD;
            default: return LANE_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] rom_pattern(input int unsigned idx, input logic odd);
        logic [31:0] v;
        v = idx * 32'd29 + (odd ? 32'h6B : 32'h11);
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/region_decoder.sv
`timescale 1ns/1ps
module region_decoder
    import memdec_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             full_mode,
    output region_t          hit
);
    always_comb begin
        if (full_mode) begin
            hit.ram = (tag == '0);
            hit.rom = &tag;
        end else begin
            hit.ram = ~tag[TAG_W-1];
            hit.rom =  tag[TAG_W-1];
        end
    end
endmodule

// File: rtl/lane_select.sv
`timescale 1ns/1ps
module lane_select
    import memdec_pkg::*;
(
    input  logic bhe_n,
    input  logic a0,
    output logic even_en,
    output logic odd_en
);
    lane_e lane;

    always_comb begin
        lane    = lane_of(bhe_n, a0);
        even_en = (lane == LANE_WORD) || (lane == LANE_EVEN);
        odd_en  = (lane == LANE_WORD) || (lane == LANE_ODD);
    end
endmodule

// File: rtl/ram_bank.sv
`timescale 1ns/1ps
module ram_bank
    import memdec_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wbyte;
    end

    assign rbyte = cells[idx];
endmodule

// File: rtl/rom_bank.sv
`timescale 1ns/1ps
module rom_bank
    import memdec_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter bit ODD   = 1'b0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] rbyte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = rom_pattern(i, ODD);
    end

    assign rbyte = cells[idx];
endmodule

// File: rtl/banked_mem_decoder.sv
`timescale 1ns/1ps
module banked_mem_decoder
    import memdec_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_dec,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              even_en,
    output logic              odd_en
);
    localparam int TAG_W   = ADDR_W - IDX_W - 1;
    localparam int N_LANES = DATA_W / BYTE_W;

    region_t           hit;
    logic [IDX_W-1:0]  idx;
    logic              lane_en   [N_LANES];
    logic [BYTE_W-1:0] ram_rd    [N_LANES];
    logic [BYTE_W-1:0] rom_rd    [N_LANES];
    logic [BYTE_W-1:0] lane_byte [N_LANES];
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    assign idx = addr[IDX_W:1];

    region_decoder #(.TAG_W(TAG_W)) u_dec (
        .tag       (addr[ADDR_W-1:IDX_W+1]),
        .full_mode (full_dec),
        .hit       (hit)
    );

    lane_select u_lane (
        .bhe_n   (bhe_n),
        .a0      (addr[0]),
        .even_en (even_en),
        .odd_en  (odd_en)
    );

    assign lane_en[0] = even_en;
    assign lane_en[1] = odd_en;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        ram_bank #(.IDX_W(IDX_W)) u_ram (
            .clk   (clk),
            .we    (hit.ram & ~wr_n & lane_en[g]),
            .idx   (idx),
            .wbyte (wdata[g*BYTE_W +: BYTE_W]),
            .rbyte (ram_rd[g])
        );

        rom_bank #(.IDX_W(IDX_W), .ODD(g == 1)) u_rom (
            .idx   (idx),
            .rbyte (rom_rd[g])
        );

        always_comb begin
            if (!lane_en[g])  lane_byte[g] = '1;
            else if (hit.ram) lane_byte[g] = ram_rd[g];
            else if (hit.rom) lane_byte[g] = rom_rd[g];
            else              lane_byte[g] = '1;
        end

        assign rd_next[g*BYTE_W +: BYTE_W] = lane_byte[g];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '1;
        else if (!rd_n) rdata_q <= rd_next;
    end

    assign rdata  = rdata_q;
    assign rom_cs = hit.rom;
    assign ram_cs = hit.ram;
endmodule

// File: rtl/memdec_checker.sv
`timescale 1ns/1ps
module memdec_checker #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              full_dec,
    input logic [ADDR_W-1:0] addr,
    input logic              bhe_n,
    input logic              rd_n,
    input logic [15:0]       rdata,
    input logic              rom_cs,
    input logic              ram_cs,
    input logic              even_en,
    input logic              odd_en
);
    a_r12_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rom_cs && ram_cs));

    a_r5_reset_vector_rom: assert property (@(posedge clk) disable iff (rst)
        (addr == {ADDR_W{1'b1}} - 20'hF) |-> rom_cs);

    a_r4_partial_low_ram: assert property (@(posedge clk) disable iff (rst)
        (!full_dec && !addr[ADDR_W-1]) |-> ram_cs);

    a_r2_no_lane: assert property (@(posedge clk) disable iff (rst)
        (bhe_n && addr[0]) |-> (!even_en && !odd_en));

    a_r2_word_lanes: assert property (@(posedge clk) disable iff (rst)
        (!bhe_n && !addr[0]) |-> (even_en && odd_en));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> $stable(rdata));

    a_r10_unmapped_ones: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !rom_cs && !ram_cs) |=> (rdata == 16'hFFFF));

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (rdata == 16'hFFFF));
endmodule

bind banked_mem_decoder memdec_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .full_dec (full_dec),
    .addr     (addr),
    .bhe_n    (bhe_n),
    .rd_n     (rd_n),
    .rdata    (rdata),
    .rom_cs   (rom_cs),
    .ram_cs   (ram_cs),
    .even_en  (even_en),
    .odd_en   (odd_en)
);

// File: tb/tb_banked_mem_decoder.sv
`timescale 1ns/1ps
module tb_banked_mem_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_dec = 1'b1;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rom_cs, ram_cs, even_en, odd_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  m_even [256];
    logic [7:0]  m_odd  [256];
    logic [15:0] last_rd = 16'hFFFF;

    always #4 clk = ~clk;

    banked_mem_decoder dut (
        .clk(clk), .rst(rst), .full_dec(full_dec), .addr(addr), .bhe_n(bhe_n),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .even_en(even_en), .odd_en(odd_en)
    );

    function automatic logic [7:0] pat(input int unsigned i, input bit odd);
        logic [31:0] v;
        v = i * 29 + (odd ? 32'h6B : 32'h11);
        return v[7:0];
    endfunction

    function automatic logic [1:0] exp_sel(input logic [19:0] a, input bit full);
        if (full) return {&a[19:9], a[19:9] == 11'd0};
        return {a[19], ~a[19]};
    endfunction

    function automatic logic [1:0] exp_lanes(input bit bhe, input bit a0);
        return {~bhe, ~a0};
    endfunction

    function automatic logic [15:0] exp_read(input logic [19:0] a, input bit bhe, input bit full);
        logic [1:0] s, l;
        logic [7:0] lo, hi;
        int unsigned i;
        s = exp_sel(a, full);
        l = exp_lanes(bhe, a[0]);
        i = a[8:1];
        lo = 8'hFF; hi = 8'hFF;
        if (s[0]) begin
            if (l[0]) lo = m_even[i];
            if (l[1]) hi = m_odd[i];
        end else if (s[1]) begin
            if (l[0]) lo = pat(i, 1'b0);
            if (l[1]) hi = pat(i, 1'b1);
        end
        return {hi, lo};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit full, input logic [19:0] a, input bit bhe,
                       input bit rd, input bit wr, input logic [15:0] wd, input string tag);
        logic [1:0]  s, l;
        logic [15:0] er;
        string       t;
        @(negedge clk);
        full_dec = full; addr = a; bhe_n = bhe; rd_n = ~rd; wr_n = ~wr; wdata = wd;
        #1;
        s = exp_sel(a, full);
        l = exp_lanes(bhe, a[0]);
        check(full ? "R3" : "R4", {14'd0, rom_cs, ram_cs}, {14'd0, s});
        check("R2", {14'd0, odd_en, even_en}, {14'd0, l});
        check("R12", {15'd0, rom_cs & ram_cs}, 16'd0);
        er = rd ? exp_read(a, bhe, full) : last_rd;
        @(posedge clk);
        #1;
        if (tag != "")       t = tag;
        else if (!rd)        t = "R9";
        else if (s == 2'b00) t = "R10";
        else if (s[1])       t = "R6";
        else                 t = "R8";
        check(t, rdata, er);
        if (wr && s[0]) begin
            if (l[0]) m_even[a[8:1]] = wd[7:0];
            if (l[1]) m_odd[a[8:1]]  = wd[15:8];
        end
        last_rd = er;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", rdata, 16'hFFFF);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", rdata, 16'hFFFF);

        // fill the data region through word writes (R8)
        for (int i = 0; i < 256; i++)
            cyc(1'b1, {11'd0, i[7:0], 1'b0}, 1'b0, 1'b0, 1'b1, 16'(i * 16'h0101) ^ 16'h5A3C, "R8");

        // reset address in both modes (R5)
        cyc(1'b1, 20'hFFFF0, 1'b0, 1'b1, 1'b0, 16'h0, "R5");
        cyc(1'b0, 20'hFFFF0, 1'b0, 1'b1, 1'b0, 16'h0, "R5");

        // shadow access in partial mode (R4)
        cyc(1'b1, 20'h00020, 1'b0, 1'b0, 1'b1, 16'h1234, "R8");
        cyc(1'b0, 20'h5C020, 1'b0, 1'b1, 1'b0, 16'h0, "R4");
        cyc(1'b0, 20'h3E021, 1'b0, 1'b0, 1'b1, 16'hC700, "R4");
        cyc(1'b1, 20'h00020, 1'b0, 1'b1, 1'b0, 16'h0, "R4");

        // writes to the program region are ignored (R7)
        cyc(1'b1, 20'hFFE04, 1'b0, 1'b0, 1'b1, 16'hDEAD, "R7");
        cyc(1'b1, 20'hFFE04, 1'b0, 1'b1, 1'b0, 16'h0, "R7");
        cyc(1'b0, 20'hA0104, 1'b0, 1'b0, 1'b1, 16'hBEEF, "R7");
        cyc(1'b0, 20'hA0104, 1'b0, 1'b1, 1'b0, 16'h0, "R7");

        // odd and even byte writes (R8)
        cyc(1'b1, 20'h00031, 1'b0, 1'b0, 1'b1, 16'hAB77, "R8");
        cyc(1'b1, 20'h00030, 1'b1, 1'b0, 1'b1, 16'h66CD, "R8");
        cyc(1'b1, 20'h00030, 1'b0, 1'b1, 1'b0, 16'h0, "R8");

        // hold while idle (R9)
        cyc(1'b1, 20'hFFF00, 1'b0, 1'b0, 1'b0, 16'h0, "R9");

        // disabled lanes and unmapped space (R10)
        cyc(1'b1, 20'h00041, 1'b1, 1'b1, 1'b0, 16'h0, "R10");
        cyc(1'b1, 20'h40000, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
        cyc(1'b1, 20'h00042, 1'b1, 1'b1, 1'b0, 16'h0, "R10");
        cyc(1'b1, 20'hFFE11, 1'b0, 1'b1, 1'b0, 16'h0, "R10");

        // read and write on the same edge (R11)
        cyc(1'b1, 20'h00050, 1'b0, 1'b1, 1'b1, 16'h0F1E, "R11");
        cyc(1'b1, 20'h00050, 1'b0, 1'b1, 1'b0, 16'h0, "R11");

        // selects with no strobe active (R12)
        cyc(1'b1, 20'h00000, 1'b0, 1'b0, 1'b0, 16'h0, "R12");
        cyc(1'b1, 20'hFFFFE, 1'b0, 1'b0, 1'b0, 16'h0, "R12");

        for (int k = 0; k < 3000; k++) begin
            logic [19:0] a;
            bit full;
            r = $urandom();
            full = (r[2:0] < 3'd5);
            case (r[4:3])
                2'd0:    a = {11'd0, r[13:5]};
                2'd1:    a = {11'h7FF, r[13:5]};
                default: a = 20'($urandom());
            endcase
            cyc(full, a, r[14], r[15], r[16], 16'($urandom()), "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule